// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This block is the digital control engine of a serial video reclocker that accepts several line rates. It selects one candidate rate at a time and drives the matching divider selection. It measures the oscillator against the reference clock and decides whether the loop has locked. The oscillator reaches the block only as a single-bit pulse input, `oscTick`, with at most one pulse per reference clock. The block counts these pulses over a window of reference-clock cycles and compares the total with the expected count for the candidate rate.

In automatic mode the controller cycles through its candidate list until a window shows a match. The current or last locked rate appears on a 3-bit code output. In manual mode that code is taken from an input, and only that rate is tried. From the lock state the block also derives the lock-detect, SD/HD, bypass-select and output-quiet signals.

Top module: `rate_hunt_ctrl`

## Requirements
- R1: Rate codes are 0=143, 1=177, 2=270, 3=360, 4=540 and 5=1485 Mb/s, and `rateCode` presents the candidate being tried, which is also the locked rate while `lockDet` is high.
- R2: In automatic mode the candidates are tried in code order 0,1,2,3,4, then 5 when `HD_EN` is set, wrapping to 0. Each candidate gets one discarded settling window followed by `DWELL` judged windows before the search moves on.
- R3: In manual mode no search runs and lock is attempted only at the selected code. Codes 6 and 7, and code 5 when `HD_EN` is clear, are ignored: the previous selection is kept and an established lock persists.
- R4: Lock is declared at the end of a judged window whose pulse count `n` satisfies 100·|n−E| ≤ E, where E = WINDOW·rate/FULL_SCALE rounded down.
- R5: Once locked, lock is kept while 50·|n−E| ≤ E. A window that breaks this bound drops lock and resumes judging at the same rate.
- R6: While `asiMode` is high in automatic mode, code 1 is skipped, so neither `rateCode`=1 nor lock at 177 Mb/s can occur.
- R7: `sdFlag` is high exactly when locked at codes 0 to 4, and low when locked at code 5 or unlocked.
- R8: `bypassSel` is high when `forceBypass` is high, or when `autoBypass` is high and lock is absent.
- R9: `outQuiet` is high when `muteN` is low and `bypassSel` is low; in bypass `muteN` has no effect.
- R10: A change of `autoMode`, or of an accepted manual code while in manual mode, drops lock at the next clock edge and restarts acquisition. Automatic mode restarts at code 0.
- R11: After reset the block is unlocked, `rateCode` is 0 and a new measurement window begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also times the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One pulse per divided oscillator period, at most one per clock |
| autoMode | input | 1 | 1 = automatic search, 0 = manual rate |
| manualCode | input | 3 | Rate code requested in manual mode |
| asiMode | input | 1 | Removes code 1 from the automatic search |
| forceBypass | input | 1 | Unconditional bypass request |
| autoBypass | input | 1 | Bypass request that applies only while unlocked |
| muteN | input | 1 | Active-low mute of the retimed output |
| lockDet | output | 1 | Lock detected |
| rateCode | output | 3 | Candidate or locked rate code; also the divider selection |
| sdFlag | output | 1 | Locked at a standard-definition rate |
| bypassSel | output | 1 | Route input straight to output |
| outQuiet | output | 1 | Force the retimed output quiet |

## Verification
The hardest situation to reach is the gap between the two tolerance bands: a lock that survives a drift the acquisition band would reject, followed by a loss of lock once the drift grows. The bench models the oscillator with a fractional phase accumulator, so the counts can be set precisely. It locks at the 270 Mb/s count, then moves the pulse rate 1.5 % off and later 3.5 % off. The skip of code 1 is checked with the oscillator sitting exactly at the skipped rate, and the search is observed through a full wrap without ever locking.

// File: rtl/rh_pkg.sv
package rh_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_EVAL   = 2'd1,
    ST_LOCK   = 2'd2
  } huntState_t;

  // strobes from control to the measurement datapath
  typedef struct packed {
    logic       restart;
    logic [2:0] rate;
  } measCtl_t;

  localparam logic [2:0] CODE_HD  = 3'd5;
  localparam logic [2:0] CODE_177 = 3'd1;

  function automatic int rateMbps(input logic [2:0] code);
    case (code)
      3'd0:    return 143;
      3'd1:    return 177;
      3'd2:    return 270;
      3'd3:    return 360;
      3'd4:    return 540;
      3'd5:    return 1485;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rh_measure.sv
module rh_measure
  import rh_pkg::*;
#(
  parameter int WINDOW     = 4096,
  parameter int FULL_SCALE = 1600
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     oscTick,
  input  measCtl_t ctl,
  output logic     winDone,
  output logic     nearOk,
  output logic     farBad
);

  localparam int WBITS = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int CBITS = $clog2(WINDOW + 1);
  localparam logic [WBITS-1:0] WLAST = WBITS'(WINDOW - 1);

  logic [WBITS-1:0] winCnt;
  logic [CBITS-1:0] oscCnt;
  int total;
  int expect_c;
  int diff;
  logic nearNow;
  logic farNow;

  function automatic int expFor(input logic [2:0] code);
    return (WINDOW * rateMbps(code)) / FULL_SCALE;
  endfunction

  always_comb begin
    total    = int'(oscCnt) + int'(oscTick);
    expect_c = expFor(ctl.rate);
    diff     = (total > expect_c) ? (total - expect_c) : (expect_c - total);
    nearNow  = (diff * 100) <= expect_c;
    farNow   = (diff * 50) > expect_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt  <= '0;
      oscCnt  <= '0;
      winDone <= 1'b0;
      nearOk  <= 1'b0;
      farBad  <= 1'b0;
    end else if (ctl.restart) begin
      winCnt  <= '0;
      oscCnt  <= '0;
      winDone <= 1'b0;
      nearOk  <= 1'b0;
      farBad  <= 1'b0;
    end else if (winCnt == WLAST) begin
      winCnt  <= '0;
      oscCnt  <= '0;
      winDone <= 1'b1;
      nearOk  <= nearNow;
      farBad  <= farNow;
    end else begin
      winCnt  <= winCnt + 1'b1;
      oscCnt  <= oscCnt + CBITS'(oscTick);
      winDone <= 1'b0;
    end
  end

  // at most one pulse per cycle: the running count never passes the cycles seen
  assert_osc_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(oscCnt) <= int'(winCnt));

endmodule

// File: rtl/rh_ctrl.sv
module rh_ctrl
  import rh_pkg::*;
#(
  parameter int DWELL = 4,
  parameter bit HD_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       winDone,
  input  logic       nearOk,
  input  logic       farBad,
  input  logic       autoMode,
  input  logic [2:0] manualCode,
  input  logic       asiMode,
  output measCtl_t   ctl,
  output logic       lockDet,
  output logic [2:0] rateCode,
  output logic       sdFlag
);

  localparam int DBITS = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [DBITS-1:0] DLAST = DBITS'(DWELL - 1);

  huntState_t state;
  logic [2:0] curRate;
  logic [2:0] manSel;
  logic [DBITS-1:0] dwellCnt;
  logic modeQ;
  logic asiQ;

  logic validCode;
  logic modeChange;
  logic codeChange;
  logic asiChange;
  logic advance;
  logic restartReq;
  logic [2:0] newRate;

  function automatic logic [2:0] nextRate(input logic [2:0] r, input logic skip177);
    logic [2:0] n;
    n = r + 3'd1;
    if (n == CODE_177 && skip177) n = 3'd2;
    if (n == CODE_HD && !HD_EN) n = 3'd0;
    if (n > CODE_HD) n = 3'd0;
    return n;
  endfunction

  always_comb begin
    validCode  = (manualCode < CODE_HD) || (manualCode == CODE_HD && HD_EN);
    modeChange = (autoMode != modeQ);
    codeChange = !autoMode && validCode && (manualCode != manSel);
    asiChange  = autoMode && (asiMode != asiQ);
    advance    = autoMode && (state == ST_EVAL) && winDone && !nearOk &&
                 (dwellCnt == DLAST);
    restartReq = modeChange || codeChange || asiChange || advance;
    if (modeChange || codeChange || asiChange)
      newRate = autoMode ? 3'd0 : (validCode ? manualCode : manSel);
    else
      newRate = nextRate(curRate, asiMode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SETTLE;
      curRate  <= 3'd0;
      manSel   <= 3'd0;
      dwellCnt <= '0;
      modeQ    <= 1'b1;
      asiQ     <= 1'b0;
    end else begin
      modeQ <= autoMode;
      asiQ  <= asiMode;
      if (validCode) manSel <= manualCode;
      if (restartReq) begin
        state    <= ST_SETTLE;
        curRate  <= newRate;
        dwellCnt <= '0;
      end else begin
        case (state)
          ST_SETTLE: if (winDone) begin
            state    <= ST_EVAL;
            dwellCnt <= '0;
          end
          ST_EVAL: if (winDone) begin
            if (nearOk) state <= ST_LOCK;
            else if (dwellCnt == DLAST) dwellCnt <= '0;
            else dwellCnt <= dwellCnt + 1'b1;
          end
          ST_LOCK: if (winDone && farBad) begin
            state    <= ST_EVAL;
            dwellCnt <= '0;
          end
          default: state <= ST_SETTLE;
        endcase
      end
    end
  end

  assign ctl.restart = restartReq;
  assign ctl.rate    = curRate;
  assign lockDet     = (state == ST_LOCK);
  assign rateCode    = curRate;
  assign sdFlag      = lockDet && (curRate != CODE_HD);

  assert_lock_from_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockDet) |-> $past(winDone && nearOk));

  assert_unlock_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockDet) |-> $past(restartReq || (winDone && farBad)));

  assert_rate_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lockDet && $past(lockDet) |-> $stable(rateCode));

  assert_asi_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    autoMode && asiMode && $past(autoMode && asiMode) |-> rateCode != CODE_177);

  assert_manual_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!autoMode) && !$stable(rateCode) |-> $past(modeChange || codeChange));

endmodule

// File: rtl/rate_hunt_ctrl.sv
module rate_hunt_ctrl
  import rh_pkg::*;
#(
  parameter int WINDOW     = 4096,
  parameter int FULL_SCALE = 1600,
  parameter int DWELL      = 4,
  parameter bit HD_EN      = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oscTick,
  input  logic       autoMode,
  input  logic [2:0] manualCode,
  input  logic       asiMode,
  input  logic       forceBypass,
  input  logic       autoBypass,
  input  logic       muteN,
  output logic       lockDet,
  output logic [2:0] rateCode,
  output logic       sdFlag,
  output logic       bypassSel,
  output logic       outQuiet
);

  measCtl_t ctl;
  logic winDone;
  logic nearOk;
  logic farBad;

  rh_measure #(.WINDOW(WINDOW), .FULL_SCALE(FULL_SCALE)) u_meas (
    .clk(clk), .rst_n(rst_n), .oscTick(oscTick), .ctl(ctl),
    .winDone(winDone), .nearOk(nearOk), .farBad(farBad)
  );

  rh_ctrl #(.DWELL(DWELL), .HD_EN(HD_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .winDone(winDone), .nearOk(nearOk),
    .farBad(farBad), .autoMode(autoMode), .manualCode(manualCode),
    .asiMode(asiMode), .ctl(ctl), .lockDet(lockDet), .rateCode(rateCode),
    .sdFlag(sdFlag)
  );

  assign bypassSel = forceBypass || (autoBypass && !lockDet);
  assign outQuiet  = !muteN && !bypassSel;

endmodule

// File: tb/rate_hunt_ctrl_tb.sv
module rate_hunt_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 2048;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oscTick = 1'b0;
  logic autoMode = 1'b1;
  logic [2:0] manualCode = 3'd0;
  logic asiMode = 1'b0;
  logic forceBypass = 1'b0;
  logic autoBypass = 1'b1;
  logic muteN = 1'b1;
  logic lockDet;
  logic [2:0] rateCode;
  logic sdFlag;
  logic bypassSel;
  logic outQuiet;

  int nTests = 0;
  int nFail = 0;
  longint phaseAcc = 0;
  longint phaseInc = 0;
  longint cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_hunt_ctrl #(.WINDOW(W), .FULL_SCALE(1600), .DWELL(D), .HD_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .oscTick(oscTick), .autoMode(autoMode),
    .manualCode(manualCode), .asiMode(asiMode), .forceBypass(forceBypass),
    .autoBypass(autoBypass), .muteN(muteN), .lockDet(lockDet),
    .rateCode(rateCode), .sdFlag(sdFlag), .bypassSel(bypassSel),
    .outQuiet(outQuiet)
  );

  // fractional oscillator model: pulse rate = f / 1600 per clock
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (phaseAcc + phaseInc >= 64'sd4294967296) begin
      phaseAcc <= phaseAcc + phaseInc - 64'sd4294967296;
      oscTick  <= 1'b1;
    end else begin
      phaseAcc <= phaseAcc + phaseInc;
      oscTick  <= 1'b0;
    end
  end

  task automatic setFreq(input real f);
    phaseInc = longint'(f / 1600.0 * 4294967296.0);
  endtask

  function automatic logic expBypass(input logic fb, input logic ab, input logic lk);
    return fb || (ab && !lk);
  endfunction

  function automatic logic expQuiet(input logic mn, input logic byp);
    return !mn && !byp;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    nTests++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic waitLock(input int maxCyc, output int got);
    got = -1;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (lockDet) begin
        got = i;
        break;
      end
    end
  endtask

  task automatic waitUnlock(input int maxCyc, output int got);
    got = -1;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (!lockDet) begin
        got = i;
        break;
      end
    end
  endtask

  task automatic randomOutputs(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      forceBypass = 1'($urandom());
      autoBypass  = 1'($urandom());
      muteN       = 1'($urandom());
      #1;
      check({tag, " R8 bypassSel"}, int'(bypassSel),
            int'(expBypass(forceBypass, autoBypass, lockDet)));
      check({tag, " R9 outQuiet"}, int'(outQuiet),
            int'(expQuiet(muteN, expBypass(forceBypass, autoBypass, lockDet))));
    end
    forceBypass = 1'b0;
    autoBypass  = 1'b1;
    muteN       = 1'b1;
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int got;
    int seq [8];
    int seqN;
    logic sawCode1;
    logic sawLock;
    logic wrapped;
    logic [2:0] prevCode;
    void'($urandom(32'd1234));
    setFreq(270.0);
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check("R11 lockDet at reset", int'(lockDet), 0);
    check("R11 rateCode at reset", int'(rateCode), 0);
    check("R11 sdFlag at reset", int'(sdFlag), 0);
    check("R8 autobypass while unlocked", int'(bypassSel), 1);
    rst_n = 1'b1;

    // R2 search order 0,1,2 and lock at 270 (R4, R1)
    seqN = 0;
    seq[0] = 0;
    seqN = 1;
    got = -1;
    for (int i = 0; i < 12 * W; i++) begin
      @(negedge clk);
      if (int'(rateCode) != seq[seqN-1] && seqN < 8) begin
        seq[seqN] = int'(rateCode);
        seqN++;
      end
      if (lockDet) begin
        got = i;
        break;
      end
    end
    check("R2 candidates visited before lock", seqN, 3);
    check("R2 second candidate", seq[1], 1);
    check("R2 third candidate", seq[2], 2);
    check("R4 locked at matching rate", int'(lockDet), 1);
    check("R1 locked rate code", int'(rateCode), 2);
    check("R2 lock time near 8 windows", int'(got >= 8 * W - 16 && got <= 8 * W + 16), 1);
    check("R7 sdFlag at SD lock", int'(sdFlag), 1);

    randomOutputs(30, "locked");

    // R5 hysteresis
    setFreq(270.0 * 1.015);
    repeat (4 * W) @(negedge clk);
    check("R5 lock kept at 1.5pct", int'(lockDet), 1);
    setFreq(270.0 * 1.035);
    waitUnlock(3 * W, got);
    check("R5 lock lost at 3.5pct", int'(got >= 0), 1);
    check("R5 rejudges same rate", int'(rateCode), 2);
    setFreq(270.0 * 1.015);
    waitLock(10 * W, got);
    check("R4 no acquisition at 1.5pct", int'(got < 0), 1);
    randomOutputs(20, "unlocked");

    // R3 manual HD lock, R7 low at HD
    @(negedge clk);
    setFreq(1485.0);
    autoMode = 1'b0;
    manualCode = 3'd5;
    waitLock(4 * W, got);
    check("R3 manual lock at code 5", int'(lockDet), 1);
    check("R3 manual rate code", int'(rateCode), 5);
    check("R7 sdFlag low at HD", int'(sdFlag), 0);

    // R3 invalid code ignored
    manualCode = 3'd7;
    repeat (3 * W) @(negedge clk);
    check("R3 code 7 ignored lock", int'(lockDet), 1);
    check("R3 code 7 ignored rate", int'(rateCode), 5);

    // R10 manual code change
    manualCode = 3'd3;
    @(negedge clk);
    check("R10 code change drops lock", int'(lockDet), 0);
    check("R3 new manual code", int'(rateCode), 3);
    setFreq(360.0);
    waitLock(4 * W, got);
    check("R3 manual lock at 360", int'(lockDet), 1);
    autoMode = 1'b1;
    @(negedge clk);
    check("R10 mode change drops lock", int'(lockDet), 0);
    check("R10 auto restarts at code 0", int'(rateCode), 0);

    // R6 asi skip with oscillator exactly at 177
    asiMode = 1'b1;
    setFreq(177.0);
    sawCode1 = 1'b0;
    sawLock = 1'b0;
    wrapped = 1'b0;
    @(negedge clk);
    prevCode = rateCode;
    for (int i = 0; i < 17 * W; i++) begin
      @(negedge clk);
      if (rateCode == 3'd1) sawCode1 = 1'b1;
      if (lockDet) sawLock = 1'b1;
      if (prevCode == 3'd5 && rateCode == 3'd0) wrapped = 1'b1;
      prevCode = rateCode;
    end
    check("R6 code 1 never tried", int'(sawCode1), 0);
    check("R6 no lock at 177", int'(sawLock), 0);
    check("R2 wrap from 5 to 0", int'(wrapped), 1);
    asiMode = 1'b0;
    waitLock(8 * W, got);
    check("R6 177 lock once asi low", int'(lockDet), 1);
    check("R6 locked code", int'(rateCode), 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule